// File: doc/BRIEF.md
# Receive Destination Address Screen

This block decides whether an incoming Ethernet frame should be kept, judging only by its 48-bit destination address. Frame bytes arrive one per cycle on a valid/ready byte stream with a start-of-frame marker and a last-byte marker. The first six bytes are the destination address, and the earliest byte is the first address octet. While those bytes stream in, the block builds the address, sorts it into unicast, multicast or broadcast, and runs a byte-serial reflected CRC-32 over it. It uses that CRC to select one bit of a 64-bit multicast hash table.

Static configuration pins supply the station address, the two 32-bit hash table words and four enables: accept everything, accept broadcast, accept every multicast, and accept multicast through the hash table. A frame that ends before its minimum length is dropped and never reaches the filter. Otherwise one decision strobe gives the verdict and the class. The stream never applies back-pressure. `in_ready` rises on the first clock edge after reset is released and stays high, so a byte is taken on every edge where `in_valid` and `in_ready` are both high.

Top module: `rxf_addr_screen`

## Requirements
- R1: `in_ready` is low while `rst_n` is low and high from the first clock edge after reset release onward; a byte is taken on each edge with `in_valid` and `in_ready` high.
- R2: For a frame of at least `MIN_LEN` (default 10) bytes, `dec_valid` is high for exactly the one cycle following the edge that takes the `MIN_LEN`-th byte, with `dec_short` low. Bytes after that, up to the next start-of-frame, produce no further strobe.
- R3: A frame whose `in_last` byte is byte number 1 to `MIN_LEN`-1 gives one strobe in the cycle after that byte, with `dec_short` = 1, `dec_accept` = 0 and `dec_class` = 0.
- R4: A byte taken with `in_sof` high always starts a new frame as byte 1. A frame cut off this way gives no strobe.
- R5: `dec_class` codes are 0 for unicast, 1 for multicast and 2 for broadcast. Broadcast means all 48 address bits are one. Multicast means bit 0 of the first address byte is one and the address is not broadcast.
- R6: With `cfg_accept_all` high, every frame that is not short is accepted.
- R7: Otherwise a broadcast frame is accepted exactly when `cfg_bcast_en` is high.
- R8: Otherwise a unicast frame is accepted exactly when its address equals {`cfg_station_hi`, `cfg_station_lo`}. The first address byte is compared with `cfg_station_hi[15:8]`, the second with `cfg_station_hi[7:0]`, and bytes 3 to 6 with `cfg_station_lo[31:24]` down to `cfg_station_lo[7:0]`.
- R9: Otherwise a multicast frame is accepted when `cfg_mcast_all` is high.
- R10: Otherwise, when `cfg_hash_en` is high, a multicast frame is accepted exactly when its table bit is set. The CRC starts at all ones, uses polynomial 0xEDB88320 shifted right, and takes each byte LSB first, with no final inversion. The index is the inverse of CRC bits [7:2]. Index bit 5 picks `cfg_hash_hi` (1) or `cfg_hash_lo` (0), and index bits [4:0] pick the bit within that word.
- R11: A multicast frame is rejected when `cfg_accept_all`, `cfg_mcast_all` and `cfg_hash_en` are all low.
- R12: Bytes with `in_valid` high that are neither `in_sof` bytes nor part of an open frame are ignored and produce no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte on `in_data` is valid |
| in_ready | output | 1 | Block can take a byte (always high after reset) |
| in_data | input | 8 | Frame byte |
| in_sof | input | 1 | This byte is the first of a frame |
| in_last | input | 1 | This byte is the last of a frame |
| cfg_station_hi | input | 16 | Station address bytes 1 and 2 |
| cfg_station_lo | input | 32 | Station address bytes 3 to 6 |
| cfg_hash_lo | input | 32 | Hash table bits for indices 0 to 31 |
| cfg_hash_hi | input | 32 | Hash table bits for indices 32 to 63 |
| cfg_accept_all | input | 1 | Accept every frame that is not short |
| cfg_bcast_en | input | 1 | Accept broadcast |
| cfg_mcast_all | input | 1 | Accept every multicast |
| cfg_hash_en | input | 1 | Accept multicast through the hash table |
| dec_valid | output | 1 | One-cycle decision strobe |
| dec_accept | output | 1 | Frame accepted |
| dec_short | output | 1 | Frame dropped for being short |
| dec_class | output | 2 | Destination class: 0 unicast, 1 multicast, 2 broadcast |

## Verification
Every result is due in the cycle after the edge that takes the deciding byte: the `MIN_LEN`-th byte, or the early `in_last` byte of a short frame. No further register stands between that byte and the outputs. The bench drives each byte on a falling edge and samples on the falling edge after the deciding byte is taken, which is exactly that cycle. A falling-edge strobe counter confirms that each frame produces exactly one strobe. Aborted frames and stray bytes are shown to add none.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int unsigned ADDR_BYTES = 6;
  localparam int unsigned ADDR_W     = ADDR_BYTES * 8;
  localparam int unsigned HASH_WORDS = 2;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned HASH_W     = $clog2(HASH_WORDS * WORD_W);
  localparam logic [31:0] CRC_POLY   = 32'hEDB88320;

  typedef enum logic [1:0] {
    CLS_UCAST = 2'd0,
    CLS_MCAST = 2'd1,
    CLS_BCAST = 2'd2
  } rxf_class_e;

  // One byte through the reflected CRC-32, least significant bit first.
  function automatic logic [31:0] crc_step_byte(logic [31:0] c, logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'd0, b};
    for (int i = 0; i < 8; i++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    end
    return r;
  endfunction
endpackage

// File: rtl/rxf_frame_track.sv
module rxf_frame_track
  import rxf_pkg::*;
#(
  parameter int unsigned MIN_LEN = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic sof,
  input  logic last,
  output logic addr_take,
  output logic addr_first,
  output logic fire_full,
  output logic fire_short
);
  localparam int unsigned CNT_W = $clog2(MIN_LEN + 1);
  localparam logic [CNT_W-1:0] ADDR_CNT = CNT_W'(ADDR_BYTES);
  localparam logic [CNT_W-1:0] MIN_CNT  = CNT_W'(MIN_LEN);
  localparam logic [CNT_W-1:0] ONE_CNT  = CNT_W'(1);

  logic             active_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic             in_frame;

  always_comb begin
    addr_first = take & sof;
    addr_take  = take & (sof | (active_q & (cnt_q < ADDR_CNT)));
    in_frame   = take & (sof | active_q);
    cnt_nxt    = sof ? ONE_CNT : (cnt_q + ONE_CNT);
    fire_full  = in_frame & (cnt_nxt == MIN_CNT);
    fire_short = in_frame & last & (cnt_nxt < MIN_CNT);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (in_frame) begin
      cnt_q    <= cnt_nxt;
      active_q <= ~(fire_full | fire_short);
    end
  end

  // R2
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (cnt_q < MIN_CNT));

  // R4
  sof_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && sof && !last) |=> (active_q && cnt_q == ONE_CNT));
endmodule

// File: rtl/rxf_addr_shift.sv
module rxf_addr_shift
  import rxf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              first,
  input  logic [7:0]        data,
  output logic [ADDR_W-1:0] addr_nxt
);
  logic [ADDR_W-1:0] addr_q;

  // Earliest byte ends up in the top octet after six shifts.
  always_comb begin
    if (!take)      addr_nxt = addr_q;
    else if (first) addr_nxt = {{(ADDR_W-8){1'b0}}, data};
    else            addr_nxt = {addr_q[ADDR_W-9:0], data};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_nxt;
  end
endmodule

// File: rtl/rxf_crc_hash.sv
module rxf_crc_hash
  import rxf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              first,
  input  logic [7:0]        data,
  output logic [HASH_W-1:0] hash_idx
);
  logic [31:0] crc_q;
  logic [31:0] crc_nxt;
  logic [31:0] crc_base;

  always_comb begin
    crc_base = first ? 32'hFFFF_FFFF : crc_q;
    crc_nxt  = take ? crc_step_byte(crc_base, data) : crc_q;
    hash_idx = ~crc_nxt[HASH_W+1:2];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) crc_q <= 32'hFFFF_FFFF;
    else        crc_q <= crc_nxt;
  end
endmodule

// File: rtl/rxf_addr_screen.sv
module rxf_addr_screen
  import rxf_pkg::*;
#(
  parameter int unsigned MIN_LEN = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_data,
  input  logic        in_sof,
  input  logic        in_last,
  input  logic [15:0] cfg_station_hi,
  input  logic [31:0] cfg_station_lo,
  input  logic [31:0] cfg_hash_lo,
  input  logic [31:0] cfg_hash_hi,
  input  logic        cfg_accept_all,
  input  logic        cfg_bcast_en,
  input  logic        cfg_mcast_all,
  input  logic        cfg_hash_en,
  output logic        dec_valid,
  output logic        dec_accept,
  output logic        dec_short,
  output logic [1:0]  dec_class
);
  logic              ready_q;
  logic              take;
  logic              addr_take;
  logic              addr_first;
  logic              fire_full;
  logic              fire_short;
  logic [ADDR_W-1:0] addr;
  logic [HASH_W-1:0] hash_idx;
  logic [WORD_W-1:0] hash_word;
  logic              hash_hit;
  logic              is_bcast;
  logic              is_mcast;
  logic              uc_hit;
  logic              acc_c;
  rxf_class_e        cls_c;

  always_ff @(posedge clk) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end
  assign in_ready = ready_q;
  assign take     = in_valid & ready_q;

  rxf_frame_track #(.MIN_LEN(MIN_LEN)) u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (take),
    .sof        (in_sof),
    .last       (in_last),
    .addr_take  (addr_take),
    .addr_first (addr_first),
    .fire_full  (fire_full),
    .fire_short (fire_short)
  );

  rxf_addr_shift u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (addr_take),
    .first    (addr_first),
    .data     (in_data),
    .addr_nxt (addr)
  );

  rxf_crc_hash u_hash (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (addr_take),
    .first    (addr_first),
    .data     (in_data),
    .hash_idx (hash_idx)
  );

  always_comb begin
    is_bcast  = &addr;
    is_mcast  = addr[ADDR_W-8] & ~is_bcast;
    uc_hit    = (addr == {cfg_station_hi, cfg_station_lo});
    hash_word = hash_idx[HASH_W-1] ? cfg_hash_hi : cfg_hash_lo;
    hash_hit  = hash_word[hash_idx[HASH_W-2:0]];
    if (is_bcast)      cls_c = CLS_BCAST;
    else if (is_mcast) cls_c = CLS_MCAST;
    else               cls_c = CLS_UCAST;
    if (cfg_accept_all) begin
      acc_c = 1'b1;
    end else begin
      unique case (cls_c)
        CLS_BCAST: acc_c = cfg_bcast_en;
        CLS_MCAST: acc_c = cfg_mcast_all | (cfg_hash_en & hash_hit);
        default:   acc_c = uc_hit;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
      dec_short  <= 1'b0;
      dec_class  <= CLS_UCAST;
    end else begin
      dec_valid <= fire_full | fire_short;
      if (fire_full | fire_short) begin
        dec_short  <= fire_short;
        dec_accept <= fire_full & acc_c;
        dec_class  <= fire_full ? cls_c : CLS_UCAST;
      end
    end
  end

  // R1
  ready_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> in_ready);

  // R3
  short_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_short) |-> (!dec_accept && dec_class == 2'd0));

  // R5
  class_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> (dec_class != 2'd3));

  // R6
  accept_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !dec_short && $past(cfg_accept_all)) |-> dec_accept);

  // R7
  bcast_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !dec_short && dec_class == 2'd2 && !$past(cfg_bcast_en)
     && !$past(cfg_accept_all)) |-> !dec_accept);

  // R11
  mcast_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_class == 2'd1 && !$past(cfg_accept_all) && !$past(cfg_mcast_all)
     && !$past(cfg_hash_en)) |-> !dec_accept);
endmodule

// File: tb/rxf_addr_screen_bench.sv
module rxf_addr_screen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MIN_LEN    = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = 8'd0;
  logic        in_sof = 1'b0;
  logic        in_last = 1'b0;
  logic [15:0] cfg_station_hi = 16'd0;
  logic [31:0] cfg_station_lo = 32'd0;
  logic [31:0] cfg_hash_lo = 32'd0;
  logic [31:0] cfg_hash_hi = 32'd0;
  logic        cfg_accept_all = 1'b0;
  logic        cfg_bcast_en = 1'b0;
  logic        cfg_mcast_all = 1'b0;
  logic        cfg_hash_en = 1'b0;
  logic        dec_valid;
  logic        dec_accept;
  logic        dec_short;
  logic [1:0]  dec_class;

  int checks  = 0;
  int errors  = 0;
  int strobes = 0;

  localparam logic [47:0] STATION = 48'h02_1A_3C_4D_5E_6F;

  rxf_addr_screen #(.MIN_LEN(MIN_LEN)) u_rxf_addr_screen (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sof(in_sof), .in_last(in_last),
    .cfg_station_hi(cfg_station_hi), .cfg_station_lo(cfg_station_lo),
    .cfg_hash_lo(cfg_hash_lo), .cfg_hash_hi(cfg_hash_hi),
    .cfg_accept_all(cfg_accept_all), .cfg_bcast_en(cfg_bcast_en),
    .cfg_mcast_all(cfg_mcast_all), .cfg_hash_en(cfg_hash_en),
    .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_short(dec_short),
    .dec_class(dec_class)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) if (rst_n && dec_valid) strobes++;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [5:0] idx_of(input logic [47:0] a);
    logic [31:0] c;
    c = 32'hFFFF_FFFF;
    for (int b = 0; b < 6; b++) begin
      c = c ^ {24'd0, a[47-8*b -: 8]};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return ~c[7:2];
  endfunction

  function automatic logic [1:0] cls_of(input logic [47:0] a);
    if (&a)    return 2'd2;
    if (a[40]) return 2'd1;
    return 2'd0;
  endfunction

  function automatic bit acc_of(input logic [47:0] a);
    logic [5:0]  ix;
    logic [63:0] tbl;
    ix  = idx_of(a);
    tbl = {cfg_hash_hi, cfg_hash_lo};
    if (cfg_accept_all) return 1'b1;
    case (cls_of(a))
      2'd2:    return cfg_bcast_en;
      2'd1:    return cfg_mcast_all ? 1'b1 : (cfg_hash_en ? tbl[ix] : 1'b0);
      default: return a == {cfg_station_hi, cfg_station_lo};
    endcase
  endfunction

  task automatic check_out(input bit e_short, input bit e_acc, input logic [1:0] e_cls,
                           input string req);
    chk(dec_valid == 1'b1, req, "dec_valid", 64'(dec_valid), 64'd1);
    chk(dec_short == e_short, req, "dec_short", 64'(dec_short), 64'(e_short));
    chk(dec_accept == e_acc, req, "dec_accept", 64'(dec_accept), 64'(e_acc));
    chk(dec_class == e_cls, req, "dec_class", 64'(dec_class), 64'(e_cls));
  endtask

  task automatic send(input logic [47:0] a, input int len, input string req);
    int n0;
    int due;
    bit e_short;
    bit e_acc;
    logic [1:0] e_cls;
    n0      = strobes;
    e_short = (len < MIN_LEN);
    e_acc   = e_short ? 1'b0 : acc_of(a);
    e_cls   = e_short ? 2'd0 : cls_of(a);
    due     = e_short ? len - 1 : MIN_LEN - 1;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (i - 1 == due) check_out(e_short, e_acc, e_cls, req);
      in_valid = 1'b1;
      in_sof   = (i == 0);
      in_last  = (i == len - 1);
      in_data  = (i < 6) ? a[47-8*i -: 8] : 8'(8'hA0 + i);
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_sof   = 1'b0;
    in_last  = 1'b0;
    if (len - 1 == due) check_out(e_short, e_acc, e_cls, req);
    @(negedge clk);
    chk(strobes == n0 + 1, req, "strobes per frame", 64'(strobes - n0), 64'd1);
  endtask

  task automatic set_cfg(input logic [3:0] c);
    {cfg_accept_all, cfg_bcast_en, cfg_mcast_all, cfg_hash_en} = c;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [47:0] mc;
    logic [63:0] one;
    int n0;
    {cfg_station_hi, cfg_station_lo} = STATION;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(in_ready == 1'b0, "R1", "in_ready in reset", 64'(in_ready), 64'd0);
    chk(dec_valid == 1'b0, "R2", "dec_valid in reset", 64'(dec_valid), 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(in_ready == 1'b1, "R1", "in_ready after reset", 64'(in_ready), 64'd1);
    chk(dec_valid == 1'b0, "R2", "dec_valid idle", 64'(dec_valid), 64'd0);

    // R5 R6 R7 R8 R9 R11: sweep of all enable combinations over address kinds
    {cfg_hash_hi, cfg_hash_lo} = 64'hF0F0_1234_8421_0FF0;
    for (int c = 0; c < 16; c++) begin
      set_cfg(4'(c));
      send(STATION, 12, "R8_match");
      send(STATION ^ 48'h1, 10, "R8_miss");
      send(48'hFFFF_FFFF_FFFF, 11, "R7_bcast");
      send(48'h01_00_5E_00_00_FB, 10, "R9_R11_mcast");
      send(48'h33_33_00_00_00_01, 13, "R10_mcast");
    end

    // R8 single-bit mismatches; flipping bit 40 makes it multicast (R5)
    set_cfg(4'b0001);
    {cfg_hash_hi, cfg_hash_lo} = '1;
    for (int b = 0; b < 48; b++) send(STATION ^ (48'h1 << b), 10, "R8_R5_flip");

    // R10 hash sweep: one-hot table hits, inverted table misses
    set_cfg(4'b0001);
    for (int k = 0; k < 64; k++) begin
      mc  = {6'(k), 2'b01, 8'h5E, 8'h10, 8'(k * 7), 8'h33, 8'(k ^ 8'h9C)};
      one = 64'd1 << idx_of(mc);
      {cfg_hash_hi, cfg_hash_lo} = one;
      send(mc, 10, "R10_hit");
      {cfg_hash_hi, cfg_hash_lo} = ~one;
      send(mc, 10, "R10_miss");
    end

    // R3 short frames, even with accept-all; R2 boundary at MIN_LEN and longer
    set_cfg(4'b1000);
    for (int len = 1; len < MIN_LEN; len++) send(STATION, len, "R3_short");
    send(STATION, MIN_LEN, "R2_exact");
    send(48'hFFFF_FFFF_FFFF, MIN_LEN + 6, "R2_long");

    // R4 abort: partial frame then a new start of frame
    set_cfg(4'b0000);
    n0 = strobes;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_sof   = (i == 0);
      in_last  = 1'b0;
      in_data  = 8'hFF;
    end
    send(STATION, 10, "R4_restart");
    chk(strobes == n0 + 1, "R4", "strobes after abort", 64'(strobes - n0), 64'd1);

    // R12 stray bytes outside a frame
    n0 = strobes;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_sof   = 1'b0;
      in_last  = (i == 11);
      in_data  = 8'(i);
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
    repeat (3) @(negedge clk);
    chk(strobes == n0, "R12", "strobes from stray bytes", 64'(strobes - n0), 64'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule